// File: doc/BRIEF.md
# I/O Delay Tap Calibration Controller

This controller owns the 8-bit tap setting of a programmable input/output delay line. The same setting serves the receive path and the transmit path of a pin, so one value is kept and the line picks its active direction by itself. After reset the tap holds a value fixed by a parameter. While the line is in use, the tap can be moved one step up or down by hand. It can also be driven one step per decision by a phase detector that reports whether sampling happens early or late.

On request the controller runs a calibration. It restarts the tap at zero and raises it by one each cycle. The delay line raises a feedback flag once the current tap delays data by a whole I/O clock period. The controller then holds that count and loads half of it, which puts the sampling clock in the middle of the data eye. If the sweep reaches the top tap and the flag has not appeared, calibration stops, raises an error flag and loads the mid-scale tap.

Top module: `iodly_tap_ctrl`

## Requirements
- R1: In reset and in the first cycle after it, `tap` equals the parameter `INIT_TAP` (16 by default), and `busy` and `cal_err` are 0.
- R2: While idle, with `pd_en` low and `cal_start` low, `step_up`=1 with `step_dn`=0 raises `tap` by one in the next cycle, and `step_dn`=1 with `step_up`=0 lowers it by one. Both high or both low leaves `tap` unchanged.
- R3: Tap moves saturate. A raise at 255 leaves 255, and a lowering at 0 leaves 0. This holds in both hand and phase-detector operation.
- R4: When `cal_start` is high while idle, the next cycle shows `tap`=0, `busy`=1 and `cal_err`=0. Each following cycle with `period_hit` low and `tap` below 255 raises `tap` by one.
- R5: A sweep that sees `period_hit` high at tap value P (0..255) ends in the next cycle with `busy`=0 and `tap`=floor(P/2). `busy` is therefore high for exactly P+1 cycles.
- R6: A sweep that is at tap 255 and sees `period_hit` low ends in the next cycle with `busy`=0, `cal_err`=1 and `tap`=128. `busy` is therefore high for 256 cycles.
- R7: While `busy` is high, `step_up`, `step_dn`, `pd_en`, `pd_early`, `pd_late` and `cal_start` have no effect on the sweep or on its result.
- R8: While idle with `pd_en` high, `pd_early`=1 with `pd_late`=0 raises `tap` by exactly one. `pd_late`=1 with `pd_early`=0 lowers it by exactly one. Both or neither leaves it unchanged. `step_up` and `step_dn` are ignored.
- R9: `cal_err` keeps its value through hand and phase-detector moves. It is cleared only by the start of the next calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start | input | 1 | Start a calibration sweep (sampled while idle) |
| period_hit | input | 1 | Feedback from the delay line: current tap covers a full I/O clock period |
| pd_en | input | 1 | Select phase-detector tracking instead of hand stepping |
| pd_early | input | 1 | Phase detector: sampling early, add delay |
| pd_late | input | 1 | Phase detector: sampling late, remove delay |
| step_up | input | 1 | Hand request: one tap more |
| step_dn | input | 1 | Hand request: one tap less |
| tap | output | 8 | Tap value shared by the input and output delay paths |
| busy | output | 1 | High during calibration; low means ready |
| cal_err | output | 1 | Last calibration found no full period within 255 taps |

## Verification
The assertions assume that `period_hit` depends only on the current tap and a fixed period length. They also assume it is monotonic during a sweep: once high at some tap, it stays high at every larger tap. The bench meets this by computing the flag as `tap >= P` from a stored period length P. The bench sweeps P over every value from 0 to 256, which includes the case where the flag never appears. It does so while driving stray hand and phase-detector requests during some of the sweeps.

// File: rtl/iodly_tap_ctrl.sv
module iodly_tap_ctrl #(
  parameter int TAP_W    = 8,
  parameter int INIT_TAP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_start,
  input  logic             period_hit,
  input  logic             pd_en,
  input  logic             pd_early,
  input  logic             pd_late,
  input  logic             step_up,
  input  logic             step_dn,
  output logic [TAP_W-1:0] tap,
  output logic             busy,
  output logic             cal_err
);

  localparam logic [TAP_W-1:0] TAP_TOP  = '1;
  localparam logic [TAP_W-1:0] TAP_MID  = TAP_W'(1 << (TAP_W - 1));
  localparam logic [TAP_W-1:0] TAP_INIT = TAP_W'(INIT_TAP);

  logic [TAP_W-1:0] tap_q;
  logic             busy_q, err_q;

  wire at_top  = (tap_q == TAP_TOP);
  wire at_zero = (tap_q == '0);
  wire up_req  = pd_en ? (pd_early & ~pd_late) : (step_up & ~step_dn);
  wire dn_req  = pd_en ? (pd_late & ~pd_early) : (step_dn & ~step_up);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tap_q  <= TAP_INIT;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (busy_q) begin
      if (period_hit) begin
        tap_q  <= tap_q >> 1;
        busy_q <= 1'b0;
      end else if (at_top) begin
        tap_q  <= TAP_MID;
        busy_q <= 1'b0;
        err_q  <= 1'b1;
      end else begin
        tap_q <= tap_q + 1'b1;
      end
    end else if (cal_start) begin
      tap_q  <= '0;
      busy_q <= 1'b1;
      err_q  <= 1'b0;
    end else if (up_req && !at_top) begin
      tap_q <= tap_q + 1'b1;
    end else if (dn_req && !at_zero) begin
      tap_q <= tap_q - 1'b1;
    end
  end

  assign tap     = tap_q;
  assign busy    = busy_q;
  assign cal_err = err_q;

  // R2, R3: hand stepping raises by one, never past the top
  a_r2_hand_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cal_start && !pd_en && step_up && !step_dn) |=>
      (tap == (($past(tap) == TAP_TOP) ? TAP_TOP : $past(tap) + 1'b1)));

  // R3: lowering at zero stays at zero
  a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cal_start && tap == '0 && ((pd_en && pd_late) || (!pd_en && step_dn))) |=> (tap == '0));

  // R4, R7: sweep climbs by one whatever the other inputs do
  a_r7_sweep_climb: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !period_hit && tap != TAP_TOP) |=> (busy && tap == $past(tap) + 1'b1));

  // R4: start clears the tap and raises busy
  a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cal_start) |=> (busy && tap == '0 && !cal_err));

  // R5: full period seen, half the count is loaded
  a_r5_half: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && period_hit) |=> (!busy && tap == ($past(tap) >> 1) && !cal_err));

  // R6: sweep exhausted, mid-scale with error
  a_r6_exhaust: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !period_hit && tap == TAP_TOP) |=> (!busy && cal_err && tap == TAP_MID));

  // R8: a phase decision moves at most one step
  a_r8_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cal_start && pd_en) |=>
      (tap == $past(tap) || tap == $past(tap) + 1'b1 || tap == $past(tap) - 1'b1));

  // R9: error flag only changes through calibration
  a_r9_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cal_start) |=> $stable(cal_err));

endmodule

// File: tb/iodly_tap_ctrl_bench.sv
module iodly_tap_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_TAP   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_start = 0, pd_en = 0, pd_early = 0, pd_late = 0, step_up = 0, step_dn = 0;
  logic [7:0] tap;
  logic busy, cal_err;
  int unsigned p_len = 300;
  int checks = 0, errors = 0;
  logic period_hit;

  assign period_hit = (int'(tap) >= p_len);

  always #(CLK_PERIOD/2) clk = ~clk;

  iodly_tap_ctrl #(.TAP_W(8), .INIT_TAP(INIT_TAP)) u_iodly_tap_ctrl (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .period_hit(period_hit),
    .pd_en(pd_en), .pd_early(pd_early), .pd_late(pd_late),
    .step_up(step_up), .step_dn(step_dn),
    .tap(tap), .busy(busy), .cal_err(cal_err));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_in();
    cal_start = 0; pd_en = 0; pd_early = 0; pd_late = 0; step_up = 0; step_dn = 0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic calibrate(input int p, input bit noise);
    int cnt;
    int exp_tap;
    int prev;
    bit climb_ok;
    p_len = p;
    cal_start = 1;
    tick();
    clr_in();
    check("R4 start tap", tap, 0);
    check("R4 start busy", busy, 1);
    check("R4 start err", cal_err, 0);
    cnt = 1;
    climb_ok = 1;
    prev = tap;
    while (busy && cnt < 400) begin
      if (noise) begin
        step_up = cnt[0]; step_dn = cnt[1]; pd_en = cnt[2];
        pd_early = cnt[0]; pd_late = ~cnt[0]; cal_start = cnt[3];
      end
      tick();
      if (busy) begin
        cnt++;
        if (tap != prev + 1) climb_ok = 0;
        prev = tap;
      end
    end
    clr_in();
    check(noise ? "R7 R4 sweep climbs" : "R4 sweep climbs", climb_ok, 1);
    if (p <= 255) begin
      exp_tap = p / 2;
      check(noise ? "R7 R5 busy length" : "R5 busy length", cnt, p + 1);
      check(noise ? "R7 R5 half tap" : "R5 half tap", tap, exp_tap);
      check("R5 no error", cal_err, 0);
    end else begin
      check(noise ? "R7 R6 busy length" : "R6 busy length", cnt, 256);
      check("R6 mid tap", tap, 128);
      check("R6 error flag", cal_err, 1);
    end
  endtask

  initial begin
    int exp_tap;
    clr_in();
    repeat (3) tick();
    check("R1 reset tap", tap, INIT_TAP);
    check("R1 reset busy", busy, 0);
    check("R1 reset err", cal_err, 0);
    rst_n = 1;
    tick();
    check("R1 tap after reset", tap, INIT_TAP);

    exp_tap = INIT_TAP;
    for (int i = 0; i < 250; i++) begin
      step_up = 1; tick();
      exp_tap = (exp_tap == 255) ? 255 : exp_tap + 1;
      check((exp_tap == 255) ? "R3 top saturate" : "R2 hand up", tap, exp_tap);
    end
    step_dn = 1; tick();
    check("R2 both high hold", tap, exp_tap);
    clr_in(); tick();
    check("R2 none hold", tap, exp_tap);
    for (int i = 0; i < 270; i++) begin
      step_dn = 1; tick();
      exp_tap = (exp_tap == 0) ? 0 : exp_tap - 1;
      check((exp_tap == 0) ? "R3 floor saturate" : "R2 hand down", tap, exp_tap);
    end
    clr_in();

    pd_en = 1; step_up = 1; tick();
    check("R8 hand ignored in pd mode", tap, 0);
    step_up = 0; pd_late = 1; tick();
    check("R3 R8 late at zero", tap, 0);
    pd_late = 0;
    for (int i = 0; i < 260; i++) begin
      pd_early = 1; pd_late = (i % 7 == 3); tick();
      if (!pd_late) exp_tap = (exp_tap == 255) ? 255 : exp_tap + 1;
      check("R8 early step", tap, exp_tap);
    end
    for (int i = 0; i < 40; i++) begin
      pd_early = (i % 5 == 1); pd_late = 1; tick();
      if (!pd_early) exp_tap = exp_tap - 1;
      check("R8 late step", tap, exp_tap);
    end
    pd_early = 0; pd_late = 0; tick();
    check("R8 no decision hold", tap, exp_tap);
    clr_in();

    for (int p = 0; p <= 256; p++) calibrate(p, (p % 3) == 1);

    check("R9 err held", cal_err, 1);
    step_up = 1; tick();
    pd_en = 1; pd_late = 1; tick();
    clr_in(); tick();
    check("R9 err after moves", cal_err, 1);
    check("R9 tap moved", tap, 128);
    calibrate(40, 0);
    check("R9 err cleared", cal_err, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule